// File: doc/BRIEF.md
# Video Line Zoom Unit

This block sits in a streaming video path between a digitiser and a frame buffer. It accepts 8-bit monochrome pixels, each with a valid flag and markers for the first pixel of a line and of a frame, and it produces a stream of the same form rescaled by a selectable factor. Enlargement by two or four works on both axes. Each pixel is repeated across the row, and each finished row is emitted again until it has been seen the chosen number of times. Reduction by two, three, four or eight works along the row only, by keeping one pixel from each group. Every input line still produces an output line, so any vertical reduction is left to software.

A three-bit mode input selects the factor. It is latched only when the first pixel of a frame is accepted, so the scale never changes within a frame. Line repetition needs a single row of storage. A row is only known to be complete when the next line or frame marker arrives, so repetition starts at that point. While it runs the block holds its input-ready output low, and the waiting pixel is taken afterwards. The last enlarged line of a frame is therefore repeated when the first pixel of the next frame shows up.

Top module: `video_zoom_unit`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1 while no input is offered.
- R2: zoomMode is sampled only when a pixel with inSof is accepted, and that pixel already uses the new value. Codes: 0 = unity, 1 = enlarge x2, 2 = enlarge x4, 3 = reduce /2, 4 = reduce /3, 5 = reduce /4, 6 = reduce /8, 7 = unity. Changes to zoomMode during a frame have no effect on that frame's output.
- R3: In unity mode each accepted pixel appears on the output in the next cycle with its data, outSol and outSof unchanged.
- R4: In a reduce-by-N mode the output keeps the 1st, (N+1)th, (2N+1)th and so on pixel of each line and drops the others. The group count restarts at every pixel with inSol. A kept pixel appears one cycle after acceptance and carries its markers.
- R5: Reduce modes never drop lines: every input line that starts with inSol produces an output line that starts with outSol.
- R6: In an enlarge-by-N mode each accepted pixel is emitted N times on consecutive cycles, starting in the cycle after acceptance. Only the first copy carries the pixel's outSol and outSof.
- R7: When a pixel with inSol or inSof is offered after an enlarged line, that line is first emitted N-1 further times before the pixel is accepted. Each pixel in these repeats is shown N times, each repeat starts with outSol, and none carries outSof.
- R8: inReady is 0 while a pixel is being repeated and while a line is being replayed. It is 1 in the cycle right after an enlarged pixel is accepted only if N is 1, which never happens.
- R9: The last enlarged line of a frame is replayed, with the enlargement factor of that frame, when the first pixel of the following frame is offered, even if that frame uses another mode.
- R10: outSof is never asserted without outSol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| zoomMode | input | 3 | Scale selection, latched at frame start |
| inValid | input | 1 | Input pixel offered |
| inReady | output | 1 | Block accepts the offered pixel this cycle |
| inData | input | 8 | Input pixel intensity |
| inSol | input | 1 | Offered pixel is first of a line |
| inSof | input | 1 | Offered pixel is first of a frame (also sets inSol) |
| outValid | output | 1 | Output pixel present |
| outData | output | 8 | Output pixel intensity |
| outSol | output | 1 | Output pixel is first of a line |
| outSof | output | 1 | Output pixel is first of a frame |

## Verification
The bench changes zoomMode in the middle of frames. A design that latched the mode too eagerly would switch scale part way through a frame and put out rows of the wrong length. Line lengths that are not multiples of the reduction factor check that the group phase restarts at each line start: a counter carried across lines would keep the wrong first pixel. A final frame in a different mode forces replay of the previous frame's last enlarged row. This catches designs that lose that row, replay it with the new factor, or accept the waiting pixel before the replay finishes. Gaps in inValid check that repetition depends on accepted pixels and not on cycles.

// File: rtl/vzu_pkg.sv
package vzu_pkg;

  typedef enum logic [1:0] {
    KIND_PASS = 2'd0,
    KIND_UP   = 2'd1,
    KIND_DOWN = 2'd2
  } zoomKind_e;

  typedef struct packed {
    zoomKind_e   kind;
    logic [3:0]  factor;
  } zoomCfg_t;

  typedef enum logic [1:0] {
    SRC_IN   = 2'd0,
    SRC_HELD = 2'd1,
    SRC_BUF  = 2'd2
  } pixSrc_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic    emit;
    logic    sol;
    logic    sof;
    logic    wrEn;
    pixSrc_e src;
  } zoomStrobe_t;

  function automatic zoomCfg_t decodeMode(input logic [2:0] m);
    zoomCfg_t c;
    case (m)
      3'd1:    begin c.kind = KIND_UP;   c.factor = 4'd2; end
      3'd2:    begin c.kind = KIND_UP;   c.factor = 4'd4; end
      3'd3:    begin c.kind = KIND_DOWN; c.factor = 4'd2; end
      3'd4:    begin c.kind = KIND_DOWN; c.factor = 4'd3; end
      3'd5:    begin c.kind = KIND_DOWN; c.factor = 4'd4; end
      3'd6:    begin c.kind = KIND_DOWN; c.factor = 4'd8; end
      default: begin c.kind = KIND_PASS; c.factor = 4'd1; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/vzu_linebuf.sv
module vzu_linebuf #(
  parameter int PIX_W = 8,
  parameter int MAX_W = 1024,
  parameter int AW    = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [PIX_W-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [PIX_W-1:0] rdData
);

  logic [PIX_W-1:0] rowMem [MAX_W];

  always_ff @(posedge clk) begin
    if (wrEn) rowMem[wrAddr] <= wrData;
  end

  assign rdData = rowMem[rdAddr];

endmodule

// File: rtl/vzu_datapath.sv
module vzu_datapath
  import vzu_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_W = 1024,
  parameter int AW    = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  zoomStrobe_t      stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [PIX_W-1:0] inData,
  output logic             outValid,
  output logic [PIX_W-1:0] outData,
  output logic             outSol,
  output logic             outSof
);

  logic [PIX_W-1:0] heldPix;
  logic [PIX_W-1:0] bufPix;
  logic [PIX_W-1:0] nextPix;

  vzu_linebuf #(.PIX_W(PIX_W), .MAX_W(MAX_W), .AW(AW)) rowBuf_i (
    .clk    (clk),
    .wrEn   (stb.wrEn),
    .wrAddr (wrAddr),
    .wrData (inData),
    .rdAddr (rdAddr),
    .rdData (bufPix)
  );

  always_comb begin
    case (stb.src)
      SRC_HELD: nextPix = heldPix;
      SRC_BUF:  nextPix = bufPix;
      default:  nextPix = inData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (stb.emit && stb.src == SRC_IN) heldPix <= inData;
    if (stb.emit) outData <= nextPix;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSol   <= 1'b0;
      outSof   <= 1'b0;
    end else begin
      outValid <= stb.emit;
      outSol   <= stb.emit & stb.sol;
      outSof   <= stb.emit & stb.sof;
    end
  end

endmodule

// File: rtl/vzu_ctrl.sv
module vzu_ctrl
  import vzu_pkg::*;
#(
  parameter int MAX_W = 1024,
  parameter int AW    = $clog2(MAX_W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    zoomMode,
  input  logic          inValid,
  input  logic          inSol,
  input  logic          inSof,
  output logic          inReady,
  output zoomStrobe_t   stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);

  localparam int PW = AW + 1;

  typedef enum logic [1:0] {
    ST_STREAM = 2'd0,
    ST_HREP   = 2'd1,
    ST_LREP   = 2'd2
  } ctrlState_e;

  ctrlState_e state;
  logic [2:0] modeReg;
  logic [3:0] phase;
  logic [3:0] curPhase;
  logic [3:0] lineFactor;
  logic [3:0] repCnt;
  logic [3:0] passCnt;
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] wrIdx;
  logic [PW-1:0] lineLen;
  logic [PW-1:0] rdPtr;
  logic pending;
  logic startReplay;
  logic accept;
  zoomCfg_t accCfg;

  always_comb begin
    accCfg      = decodeMode(inSof ? zoomMode : modeReg);
    curPhase    = inSol ? 4'd0 : phase;
    wrIdx       = inSol ? '0 : wrPtr;
    startReplay = (state == ST_STREAM) && inValid && (inSol || inSof) && pending;
    inReady     = (state == ST_STREAM) && !startReplay;
    accept      = inValid && inReady;
    wrAddr      = wrIdx[AW-1:0];
    rdAddr      = rdPtr[AW-1:0];

    stb      = '0;
    stb.src  = SRC_IN;
    case (state)
      ST_STREAM: begin
        if (accept) begin
          stb.sol = inSol;
          stb.sof = inSof;
          case (accCfg.kind)
            KIND_DOWN: stb.emit = (curPhase == 4'd0);
            KIND_UP: begin
              stb.emit = 1'b1;
              stb.wrEn = (wrIdx < PW'(MAX_W));
            end
            default:   stb.emit = 1'b1;
          endcase
        end
      end
      ST_HREP: begin
        stb.emit = 1'b1;
        stb.src  = SRC_HELD;
      end
      ST_LREP: begin
        stb.emit = 1'b1;
        stb.src  = SRC_BUF;
        stb.sol  = (rdPtr == '0) && (repCnt == 4'd0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_STREAM;
      modeReg    <= 3'd0;
      phase      <= 4'd0;
      lineFactor <= 4'd1;
      repCnt     <= 4'd0;
      passCnt    <= 4'd0;
      wrPtr      <= '0;
      lineLen    <= '0;
      rdPtr      <= '0;
      pending    <= 1'b0;
    end else begin
      case (state)
        ST_STREAM: begin
          if (startReplay) begin
            state   <= ST_LREP;
            rdPtr   <= '0;
            repCnt  <= 4'd0;
            passCnt <= 4'd1;
          end else if (accept) begin
            if (inSof) modeReg <= zoomMode;
            if (accCfg.kind == KIND_DOWN) begin
              phase <= (curPhase + 4'd1 == accCfg.factor) ? 4'd0 : curPhase + 4'd1;
            end
            if (accCfg.kind == KIND_UP) begin
              if (wrIdx < PW'(MAX_W)) begin
                wrPtr   <= wrIdx + PW'(1);
                lineLen <= wrIdx + PW'(1);
              end
              pending    <= 1'b1;
              lineFactor <= accCfg.factor;
              repCnt     <= 4'd1;
              state      <= ST_HREP;
            end
          end
        end
        ST_HREP: begin
          if (repCnt == lineFactor - 4'd1) begin
            repCnt <= 4'd0;
            state  <= ST_STREAM;
          end else begin
            repCnt <= repCnt + 4'd1;
          end
        end
        ST_LREP: begin
          if (repCnt == lineFactor - 4'd1) begin
            repCnt <= 4'd0;
            if (rdPtr == lineLen - PW'(1)) begin
              rdPtr <= '0;
              if (passCnt == lineFactor - 4'd1) begin
                pending <= 1'b0;
                state   <= ST_STREAM;
              end else begin
                passCnt <= passCnt + 4'd1;
              end
            end else begin
              rdPtr <= rdPtr + PW'(1);
            end
          end else begin
            repCnt <= repCnt + 4'd1;
          end
        end
        default: state <= ST_STREAM;
      endcase
    end
  end

endmodule

// File: rtl/video_zoom_unit.sv
module video_zoom_unit
  import vzu_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_W = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       zoomMode,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] inData,
  input  logic             inSol,
  input  logic             inSof,
  output logic             outValid,
  output logic [PIX_W-1:0] outData,
  output logic             outSol,
  output logic             outSof
);

  localparam int AW = $clog2(MAX_W);

  zoomStrobe_t   stb;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  vzu_ctrl #(.MAX_W(MAX_W), .AW(AW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .zoomMode (zoomMode),
    .inValid  (inValid),
    .inSol    (inSol),
    .inSof    (inSof),
    .inReady  (inReady),
    .stb      (stb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr)
  );

  vzu_datapath #(.PIX_W(PIX_W), .MAX_W(MAX_W), .AW(AW)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData),
    .outSol   (outSol),
    .outSof   (outSof)
  );

endmodule

// File: rtl/vzu_chk.sv
module vzu_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       zoomMode,
  input logic             inValid,
  input logic             inReady,
  input logic [PIX_W-1:0] inData,
  input logic             inSof,
  input logic             outValid,
  input logic [PIX_W-1:0] outData,
  input logic             outSol,
  input logic             outSof
);

  logic frameAcc;
  assign frameAcc = inValid && inReady && inSof;

  // R10
  sof_has_sol_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outSol);

  // R3
  pass_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameAcc && (zoomMode == 3'd0 || zoomMode == 3'd7)
      |=> outValid && outSof && outData == $past(inData));

  // R6
  up_first_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameAcc && (zoomMode == 3'd1 || zoomMode == 3'd2)
      |=> outValid && outSol && outData == $past(inData));

  // R8
  up_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameAcc && (zoomMode == 3'd1 || zoomMode == 3'd2) |=> !inReady);

  // R4
  down_keep_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameAcc && zoomMode >= 3'd3 && zoomMode <= 3'd6
      |=> outValid && outSof && outData == $past(inData));

endmodule

bind video_zoom_unit vzu_chk #(.PIX_W(PIX_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .zoomMode (zoomMode),
  .inValid  (inValid),
  .inReady  (inReady),
  .inData   (inData),
  .inSof    (inSof),
  .outValid (outValid),
  .outData  (outData),
  .outSol   (outSol),
  .outSof   (outSof)
);

// File: tb/video_zoom_unit_tb_top.sv
module video_zoom_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] zoomMode = 3'd0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inData = 8'd0;
  logic       inSol = 1'b0;
  logic       inSof = 1'b0;
  logic       outValid;
  logic [7:0] outData;
  logic       outSol;
  logic       outSof;

  always #4 clk = ~clk;

  video_zoom_unit dut_i (
    .clk(clk), .rstN(rstN), .zoomMode(zoomMode),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .inSol(inSol), .inSof(inSof),
    .outValid(outValid), .outData(outData),
    .outSol(outSol), .outSof(outSof)
  );

  typedef struct {
    logic [7:0] d;
    logic       sol;
    logic       sof;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic monOn = 1'b0;
  string tagOverride = "";

  // reference model state
  int   modeM = 0;
  int   phaseM = 0;
  int   facM = 1;
  bit   pendM = 0;
  logic [7:0] lineM[$];

  function automatic int kindOf(input int m);
    if (m == 1 || m == 2) return 1;
    if (m >= 3 && m <= 6) return 2;
    return 0;
  endfunction

  function automatic int factorOf(input int m);
    case (m)
      1: return 2;
      2: return 4;
      3: return 2;
      4: return 3;
      5: return 4;
      6: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic pushExp(input logic [7:0] d, input logic sol, input logic sof, input string req);
    expItem_t e;
    e.d = d; e.sol = sol; e.sof = sof;
    e.req = (tagOverride != "") ? tagOverride : req;
    expQ.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic modelAccept(input logic [7:0] d, input logic sol, input logic sof);
    int f;
    if ((sol || sof) && pendM) begin
      // R7 / R9: replay the held line N-1 more times before the new pixel
      for (int p = 1; p < facM; p++)
        for (int i = 0; i < lineM.size(); i++)
          for (int r = 0; r < facM; r++)
            pushExp(lineM[i], (i == 0 && r == 0), 1'b0, "R7");
      pendM = 0;
    end
    if (sof) modeM = int'(zoomMode);
    f = factorOf(modeM);
    case (kindOf(modeM))
      1: begin
        if (sol) lineM.delete();
        lineM.push_back(d);
        pendM = 1;
        facM = f;
        for (int r = 0; r < f; r++)
          pushExp(d, (r == 0) ? sol : 1'b0, (r == 0) ? sof : 1'b0, "R6");
      end
      2: begin
        if (sol) phaseM = 0;
        if (phaseM == 0) pushExp(d, sol, sof, sol ? "R5" : "R4");
        phaseM = (phaseM + 1) % f;
      end
      default: pushExp(d, sol, sof, "R3");
    endcase
  endtask

  task automatic sendPix(input logic [7:0] d, input logic sol, input logic sof);
    int m;
    modelAccept(d, sol, sof);
    m = modeM;
    @(negedge clk);
    inValid = 1'b1; inData = d; inSol = sol; inSof = sof;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    inValid = 1'b0; inSol = 1'b0; inSof = 1'b0;
    if (kindOf(m) == 1) begin
      @(negedge clk);
      #1;
      // R8: ready held low while the pixel repeats
      check(inReady == 1'b0, "R8", "inReady during repeat", int'(inReady), 0);
    end
  endtask

  task automatic sendLine(input int base, input int n, input bit first, input bit gaps);
    for (int i = 0; i < n; i++) begin
      sendPix(8'((base + i * 7) & 255), (i == 0), first && (i == 0));
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        @(negedge clk);
      end
    end
  endtask

  task automatic sendFrame(input int mode, input int lines, input int width, input int base, input bit gaps);
    zoomMode = 3'(mode);
    for (int l = 0; l < lines; l++)
      sendLine(base + l * 40, width, (l == 0), gaps);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (monOn && outValid) begin
      if (outSof) check(outSol == 1'b1, "R10", "outSol with outSof", int'(outSol), 1);
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "unexpected output pixel", int'(outData), -1);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(outData == e.d, e.req, "outData", int'(outData), int'(e.d));
        check(outSol == e.sol && outSof == e.sof, e.req, "markers sol*2+sof",
              int'({outSol, outSof}), int'({e.sol, e.sof}));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "R8", "watchdog expired", cycles, 150000);
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
    monOn = 1'b1;

    sendFrame(0, 2, 5, 10, 1'b0);   // R3 unity
    sendFrame(3, 3, 7, 20, 1'b1);   // R4/R5 reduce by 2, odd width
    sendFrame(6, 2, 17, 5, 1'b0);   // R4 reduce by 8
    sendFrame(5, 2, 10, 90, 1'b0);  // R4 reduce by 4

    // R2: mode change mid-frame must be ignored (reduce by 3 stays)
    tagOverride = "R2";
    zoomMode = 3'd4;
    sendLine(60, 8, 1'b1, 1'b0);
    zoomMode = 3'd2;
    sendLine(120, 8, 1'b0, 1'b0);
    tagOverride = "";

    sendFrame(1, 3, 4, 30, 1'b1);   // R6/R7 enlarge x2 with gaps

    // R2: enlarge x4, change to unity mid-frame
    zoomMode = 3'd2;
    sendLine(200, 3, 1'b1, 1'b0);
    zoomMode = 3'd0;
    tagOverride = "R2";
    sendLine(150, 2, 1'b0, 1'b0);
    tagOverride = "";

    // R9: next frame in reduce mode triggers replay of last x4 line
    tagOverride = "R9";
    zoomMode = 3'd3;
    sendPix(8'd77, 1'b1, 1'b1);
    tagOverride = "";
    sendLine(80, 5, 1'b0, 1'b0);

    sendFrame(7, 1, 3, 44, 1'b0);   // R2 code 7 acts as unity

    repeat (60) @(negedge clk);
    check(expQ.size() == 0, "R7", "expected pixels left", expQ.size(), 0);
    finishRun();
  end

endmodule